// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Dual-Half Dot-Product Mode

This block is a two-stage arithmetic pipeline for filter and transform datapaths. Each cycle it takes two 18-bit operands and forms one product. A plain mode gives an 18x18 signed product or a 17x17 unsigned product. A dot mode splits each operand into two 9-bit halves, multiplies them crosswise, adds the two partial products and scales the sum by 2^9. A 44-bit result register either loads that product or folds it into its running value, by addition or by subtraction. That covers multiply, multiply-add, multiply-subtract and long accumulations.

Operand, mode and control inputs are sampled together in the first stage. The product and the add/subtract and accumulate controls are registered there. The second stage updates the result register one cycle later. A single enable advances both stages at once, so a low enable freezes the whole pipeline. The reset is synchronous and active low, and it clears both stages.

Top module: `mac_dot_unit`

## Requirements
- R1: With sign_sel=1 and dot_sel=0, the product is the two's-complement product of a_in[17:0] and b_in[17:0], sign-extended to 44 bits.
- R2: With sign_sel=0 and dot_sel=0, the product is a_in[16:0] times b_in[16:0] as unsigned numbers, zero-extended to 44 bits. Bit 17 of each operand has no effect.
- R3: With dot_sel=1, the product is (a_in[8:0]*b_in[17:9] + a_in[17:9]*b_in[8:0]) shifted left by 9. Each 9-bit half is two's complement when sign_sel=1 and unsigned when sign_sel=0. The low 9 bits of the product are therefore zero.
- R4: With acc_sel=0, the result register loads the product when sub_sel=0 and the negated product when sub_sel=1.
- R5: With acc_sel=1, the result register becomes its old value plus the product (sub_sel=0) or minus the product (sub_sel=1).
- R6: All result arithmetic wraps modulo 2^44.
- R7: Operands sampled at a rising edge with en=1 reach the result output after the second rising edge with en=1. Modes and controls can change on every cycle.
- R8: While en=0 the result and the registered product both hold. Operand and control inputs have no effect during that time.
- R9: A rising edge with rst_n=0 clears the registered product, its registered controls and the result to zero, whatever the value of en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances both pipeline stages when high |
| a_in | input | 18 | First operand |
| b_in | input | 18 | Second operand |
| sign_sel | input | 1 | 1 = signed operands, 0 = unsigned |
| dot_sel | input | 1 | 1 = dual-half dot product, 0 = plain product |
| sub_sel | input | 1 | 1 = subtract product, 0 = add product |
| acc_sel | input | 1 | 1 = accumulate into result, 0 = load result |
| result | output | 44 | Result register |

## Verification
The pipeline has two stages, so the second stage can fold product n into the result in the same cycle that the first stage forms product n+1 under a different mode. The vector table feeds one operand pair per cycle with no gaps. It switches between signed, unsigned and dot modes, and between load and accumulate, on back-to-back cycles. Each result is compared with a value worked out by hand two samples after its operands went in. Reset and enable are also made to meet: reset is asserted with en high and a nonzero product pending, and an accumulate directly after release must still produce zero.

// File: rtl/mac_pkg.sv
// Package: shared types for the multiply-accumulate unit.
// Assumes: both pipeline stages use the same control bundle.
package mac_pkg;

    // Controls that travel with a product from stage one to stage two
    typedef struct packed {
        logic sub;   // 1 = subtract product
        logic acc;   // 1 = fold into running result
    } mac_ctrl_t;

endpackage

// File: rtl/mac_product_stage.sv
// Module: first pipeline stage. Forms a plain or dual-half dot product from two
// operands, extends it to the accumulator width and registers it together with
// the add/subtract and accumulate controls.
// Assumes: OP_W is even (the dot mode splits operands into two equal halves),
// and ACC_W is wide enough for both the plain product and the scaled dot sum.
module mac_product_stage
    import mac_pkg::*;
#(
    parameter int OP_W  = 18,
    parameter int ACC_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    input  logic             sign_sel,
    input  logic             dot_sel,
    input  mac_ctrl_t        ctrl_in,
    output logic [ACC_W-1:0] prod_q,
    output mac_ctrl_t        ctrl_q
);

    localparam int HALF_W = OP_W / 2;
    localparam int PW     = 2 * OP_W + 2;     // plain product width with sign room
    localparam int DW     = 2 * HALF_W + 4;   // dot sum width with sign and carry room
    localparam int UW     = OP_W - 1;         // unsigned operand width

    logic [PW-1:0]    a_ext, b_ext, plain_p;
    logic [ACC_W-1:0] plain_full, dot_full, prod_d;
    logic [DW-1:0]    part [2];
    logic [DW-1:0]    dot_sum;

    // Extend plain operands: sign-extend full width, or zero-extend the low bits
    always_comb begin
        if (sign_sel) begin
            a_ext = {{(PW-OP_W){a_in[OP_W-1]}}, a_in};
            b_ext = {{(PW-OP_W){b_in[OP_W-1]}}, b_in};
        end else begin
            a_ext = {{(PW-UW){1'b0}}, a_in[UW-1:0]};
            b_ext = {{(PW-UW){1'b0}}, b_in[UW-1:0]};
        end
        plain_p    = a_ext * b_ext;
        plain_full = {{(ACC_W-PW){plain_p[PW-1]}}, plain_p};
    end

    // One crosswise half product per slot: slot k pairs a half k with b half 1-k
    for (genvar k = 0; k < 2; k++) begin : g_cross
        logic [HALF_W-1:0] ah, bh;
        logic [DW-1:0]     ah_x, bh_x;
        assign ah   = a_in[k*HALF_W +: HALF_W];
        assign bh   = b_in[(1-k)*HALF_W +: HALF_W];
        assign ah_x = {{(DW-HALF_W){sign_sel & ah[HALF_W-1]}}, ah};
        assign bh_x = {{(DW-HALF_W){sign_sel & bh[HALF_W-1]}}, bh};
        assign part[k] = ah_x * bh_x;
    end

    // Sum the crosswise products, extend and scale by 2^HALF_W
    always_comb begin
        dot_sum  = part[0] + part[1];
        dot_full = {{(ACC_W-DW){dot_sum[DW-1]}}, dot_sum} << HALF_W;
        prod_d   = dot_sel ? dot_full : plain_full;
    end

    // Product register with its controls; held while en is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            ctrl_q <= '0;
        end else if (en) begin
            prod_q <= prod_d;
            ctrl_q <= ctrl_in;
        end
    end

    // R2
    unsigned_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sign_sel && !dot_sel) |=> (prod_q[ACC_W-1:2*UW] == '0));

    // R3
    dot_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dot_sel) |=> (prod_q[HALF_W-1:0] == '0));

endmodule

// File: rtl/mac_accum_stage.sv
// Module: second pipeline stage. Loads, adds or subtracts the registered product
// into the result register, wrapping modulo 2^ACC_W.
// Assumes: product and controls arrive already aligned from the first stage.
module mac_accum_stage
    import mac_pkg::*;
#(
    parameter int ACC_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] prod,
    input  mac_ctrl_t        ctrl,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] base, acc_d;

    // Pick zero (load) or the old value (accumulate), then add or subtract
    always_comb begin
        base  = ctrl.acc ? acc_q : '0;
        acc_d = ctrl.sub ? (base - prod) : (base + prod);
    end

    // Result register; held while en is low
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (en) acc_q <= acc_d;
    end

    // R4
    load_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctrl.acc && !ctrl.sub) |=> (acc_q == $past(prod)));

    // R5
    acc_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctrl.acc && ctrl.sub) |=> (acc_q + $past(prod) == $past(acc_q)));

endmodule

// File: rtl/mac_dot_unit.sv
// Module: top of the multiply-accumulate unit. Stage one forms the product,
// stage two updates the 44-bit result; latency is two enabled cycles.
// Assumes: a synchronous active-low reset and one enable for the whole pipeline.
module mac_dot_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 18,
    parameter int ACC_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    input  logic             sign_sel,
    input  logic             dot_sel,
    input  logic             sub_sel,
    input  logic             acc_sel,
    output logic [ACC_W-1:0] result
);

    mac_ctrl_t        ctrl_d, ctrl_q;
    logic [ACC_W-1:0] prod_q;

    // Bundle the per-operation controls
    always_comb begin
        ctrl_d.sub = sub_sel;
        ctrl_d.acc = acc_sel;
    end

    mac_product_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .a_in     (a_in),
        .b_in     (b_in),
        .sign_sel (sign_sel),
        .dot_sel  (dot_sel),
        .ctrl_in  (ctrl_d),
        .prod_q   (prod_q),
        .ctrl_q   (ctrl_q)
    );

    mac_accum_stage #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .prod  (prod_q),
        .ctrl  (ctrl_q),
        .acc_q (result)
    );

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(result) && $stable(prod_q)));

endmodule

// File: tb/mac_dot_unit_test.sv
module mac_dot_unit_test;

    typedef struct packed {
        logic [15:0] tag;
        logic [17:0] a;
        logic [17:0] b;
        logic        sgn;
        logic        dot;
        logic        sub;
        logic        acc;
        logic [43:0] exp;
    } vec_t;

    localparam int NV = 13;
    // Fields: tag, a, b, signed, dot, sub, accumulate, expected result
    localparam vec_t VECS [NV] = '{
        '{"R1", 18'h00003, 18'h00005, 1'b1, 1'b0, 1'b0, 1'b0, 44'h0000000000F},
        '{"R1", 18'h3FFFE, 18'h00007, 1'b1, 1'b0, 1'b0, 1'b1, 44'h00000000001},
        '{"R5", 18'h00064, 18'h3FFFF, 1'b1, 1'b0, 1'b1, 1'b1, 44'h00000000065},
        '{"R2", 18'h1FFFF, 18'h00002, 1'b0, 1'b0, 1'b0, 1'b0, 44'h0000003FFFE},
        '{"R2", 18'h30004, 18'h20003, 1'b0, 1'b0, 1'b0, 1'b0, 44'h0000003000C},
        '{"R4", 18'h00004, 18'h00005, 1'b1, 1'b0, 1'b1, 1'b0, 44'hFFFFFFFFFEC},
        '{"R3", 18'h00403, 18'h00805, 1'b1, 1'b1, 1'b0, 1'b0, 44'h00000002C00},
        '{"R3", 18'h3FE01, 18'h003FE, 1'b1, 1'b1, 1'b0, 1'b1, 44'h00000003200},
        '{"R3", 18'h3FFFF, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 44'h0000FF00400},
        '{"R1", 18'h20000, 18'h20000, 1'b1, 1'b0, 1'b0, 1'b0, 44'h00400000000},
        '{"R5", 18'h20000, 18'h1FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 44'h00000020000},
        '{"R4", 18'h3FFFF, 18'h00001, 1'b1, 1'b0, 1'b0, 1'b0, 44'hFFFFFFFFFFF},
        '{"R6", 18'h00001, 18'h00001, 1'b0, 1'b0, 1'b0, 1'b1, 44'h00000000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [17:0] a_in = '0, b_in = '0;
    logic        sign_sel = 1'b0, dot_sel = 1'b0, sub_sel = 1'b0, acc_sel = 1'b0;
    logic [43:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mac_dot_unit uut (
        .clk(clk), .rst_n(rst_n), .en(en), .a_in(a_in), .b_in(b_in),
        .sign_sel(sign_sel), .dot_sel(dot_sel), .sub_sel(sub_sel),
        .acc_sel(acc_sel), .result(result)
    );

    task automatic check(input string req, input logic [43:0] act, input logic [43:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [17:0] a, input logic [17:0] b, input logic sg,
                         input logic dt, input logic sb, input logic ac);
        a_in = a; b_in = b; sign_sel = sg; dot_sel = dt; sub_sel = sb; acc_sel = ac;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state (R9)
        repeat (3) @(negedge clk);
        check("R9 reset state", result, 44'h0);
        rst_n = 1'b1;
        en    = 1'b1;

        // Vector table: one operation per cycle, result two edges later (R7)
        for (int n = 0; n < NV + 2; n++) begin
            @(negedge clk);
            if (n >= 2) check(string'(VECS[n-2].tag), result, VECS[n-2].exp);
            if (n < NV)
                drive(VECS[n].a, VECS[n].b, VECS[n].sgn, VECS[n].dot,
                      VECS[n].sub, VECS[n].acc);
            else
                drive(18'h0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        end

        // Reset with en high and a nonzero product about to be captured (R9)
        drive(18'h00007, 18'h00009, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);          // result now 0 + pending 0 from above
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears result", result, 44'h0);
        rst_n = 1'b1;
        drive(18'h0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 reset clears product", result, 44'h0);

        // Stall: product 15 (load) captured, then en low with other inputs (R8)
        drive(18'h00003, 18'h00005, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        en = 1'b0;
        drive(18'h00064, 18'h00064, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 hold while disabled", result, 44'h0);
        end
        en = 1'b1;
        drive(18'h0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 held product resumes", result, 44'h0000000000F);

        // Latency: 2*2 loaded, visible only after the second edge (R7)
        drive(18'h00002, 18'h00002, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 not after one edge", result, 44'h0);
        drive(18'h0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R7 after two edges", result, 44'h00000000004);

        // Unsigned dot with only top bits set: 256*256*2 << 9 (R3)
        drive(18'h20100, 18'h20100, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        drive(18'h0, 18'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R3 unsigned halves", result, 44'h00004000000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule